// File: doc/BRIEF.md
# Dual-Core Power Mode Controller

This block follows the operating mode of a chip with two processors: both running, only processor 0 running, only processor 1 running, or both asleep with the peripherals still clocked. It watches the sleep-instruction strobes from each processor, two control bits that govern processor 0's sleep, the reset requests and the interrupt controller's request lines. From these it keeps one registered mode value. From that mode it drives a halt line per processor and two one-cycle event pulses: one for a refused sleep and one for an interrupt that woke the chip.

All inputs are sampled on the rising clock edge, and every output reflects that edge at once. The block carries no data stream, so it has no valid/ready handshake. Each pin is a plain level or a single-cycle strobe, and nothing is held back. A new input pattern may arrive every cycle.

Top module: `dual_core_pmc`

## Requirements
- R1: While `por_rst` or `man_rst` is high at a clock edge, the mode becomes dual-processor and both pulses are low, whatever the previous mode and any interrupt in the same cycle.
- R2: `mode` encodes 2'b00 dual-processor, 2'b01 only processor 0 running, 2'b10 only processor 1 running, 2'b11 dual-sleep.
- R3: In mode 01, a `cpu0_sleep` strobe with `slperr_en`=0 and `stby_sel`=0 moves to mode 11 at the next edge.
- R4: In mode 01, a `cpu0_sleep` strobe with `slperr_en`=1 leaves the mode at 01 and raises `sleep_err` for exactly one cycle, regardless of `stby_sel`.
- R5: In mode 01, a `cpu0_sleep` strobe with `slperr_en`=0 and `stby_sel`=1 leaves the mode at 01 with no pulse.
- R6: In mode 10, a `cpu1_sleep` strobe moves to mode 11 whatever `stby_sel` and `slperr_en` hold.
- R7: In mode 00, `cpu1_sleep` (alone or together with `cpu0_sleep`) moves to 01, and `cpu0_sleep` alone moves to 10.
- R8: In modes 01 and 10 the strobe of the halted processor has no effect, and in mode 11 both strobes have no effect.
- R9: `cpu0_halt` is high exactly in modes 10 and 11, and `cpu1_halt` is high exactly in modes 01 and 11.
- R10: In mode 11, processor i takes an interrupt only when `irq_req`=1, `accept_en[i]`=1 and either `irq_nmi`=1 or `irq_lvl` is strictly greater than its mask. A level equal to or below the mask leaves the chip asleep.
- R11: When an interrupt wakes the chip from mode 11, the mode becomes 00 if both processors take it, 01 if only processor 0 takes it and 10 if only processor 1 takes it. It stays 11 if neither takes it.
- R12: `irq_exc` pulses for one cycle, in the same cycle as the new mode, exactly when a wake from mode 11 happens. Interrupts in the other modes leave it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset request, active high, synchronous |
| man_rst | input | 1 | Manual reset request, active high, synchronous |
| cpu0_sleep | input | 1 | Sleep-instruction strobe from processor 0 |
| cpu1_sleep | input | 1 | Sleep-instruction strobe from processor 1 |
| stby_sel | input | 1 | Standby select; when set, processor 0's sleep does not enter dual-sleep |
| slperr_en | input | 1 | Sleep-error enable for processor 0 |
| irq_req | input | 1 | Interrupt request present |
| irq_nmi | input | 1 | Request is non-maskable |
| irq_lvl | input | LVL_W | Priority level of the request |
| cpu0_mask | input | LVL_W | Mask level of processor 0 |
| cpu1_mask | input | LVL_W | Mask level of processor 1 |
| accept_en | input | 2 | Per-processor interrupt-accept enable, bit i for processor i |
| mode | output | 2 | Current mode (encoding in R2) |
| cpu0_halt | output | 1 | Processor 0 halted |
| cpu1_halt | output | 1 | Processor 1 halted |
| sleep_err | output | 1 | One-cycle sleep-error exception pulse |
| irq_exc | output | 1 | One-cycle interrupt-exception strobe on wake |

## Verification
The bench targets the boundary where the interrupt level equals a processor's mask. A design that compares with greater-or-equal would wake there when it should stay asleep. It also covers a wake that reaches only one processor, where a design that looks only at the enable bits and ignores each processor's own mask would go to the wrong mode. It checks that processor 0's sleep-error bit wins over its standby bit, and that processor 1 ignores both bits. It checks reset landing in the same cycle as a non-maskable wake, where a design with the wrong priority would pulse `irq_exc` or report a single-processor mode.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    MODE_DUAL   = 2'b00,
    MODE_SOLO0  = 2'b01,
    MODE_SOLO1  = 2'b10,
    MODE_DSLEEP = 2'b11
  } pmc_mode_e;
endpackage

// File: rtl/pmc_sleep_gate.sv
// Decides the mode change caused by sleep-instruction strobes.
module pmc_sleep_gate
  import pmc_pkg::*;
(
  input  pmc_mode_e cur_mode,
  input  logic      cpu0_sleep,
  input  logic      cpu1_sleep,
  input  logic      stby_sel,
  input  logic      slperr_en,
  output logic      sleep_move,
  output pmc_mode_e sleep_dest,
  output logic      sleep_fault
);
  always_comb begin
    sleep_move  = 1'b0;
    sleep_dest  = cur_mode;
    sleep_fault = 1'b0;
    unique case (cur_mode)
      MODE_DUAL: begin
        // processor 1 stopping wins when both stop together
        if (cpu1_sleep) begin
          sleep_move = 1'b1;
          sleep_dest = MODE_SOLO0;
        end else if (cpu0_sleep) begin
          sleep_move = 1'b1;
          sleep_dest = MODE_SOLO1;
        end
      end
      MODE_SOLO0: begin
        if (cpu0_sleep) begin
          if (slperr_en) begin
            sleep_fault = 1'b1;
          end else if (!stby_sel) begin
            sleep_move = 1'b1;
            sleep_dest = MODE_DSLEEP;
          end
        end
      end
      MODE_SOLO1: begin
        if (cpu1_sleep) begin
          sleep_move = 1'b1;
          sleep_dest = MODE_DSLEEP;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pmc_wake_arb.sv
// Per-processor interrupt acceptance and the resulting wake destination.
module pmc_wake_arb
  import pmc_pkg::*;
#(
  parameter int LVL_W = 4,
  parameter int NCPU  = 2
) (
  input  logic                       irq_req,
  input  logic                       irq_nmi,
  input  logic [LVL_W-1:0]           irq_lvl,
  input  logic [NCPU-1:0][LVL_W-1:0] cpu_mask,
  input  logic [NCPU-1:0]            accept_en,
  output logic                       wake,
  output pmc_mode_e                  wake_dest
);
  logic [NCPU-1:0] taken;

  for (genvar g = 0; g < NCPU; g++) begin : g_take
    assign taken[g] = irq_req & accept_en[g] & (irq_nmi | (irq_lvl > cpu_mask[g]));
  end

  assign wake = |taken;

  always_comb begin
    unique case (taken[1:0])
      2'b11:   wake_dest = MODE_DUAL;
      2'b01:   wake_dest = MODE_SOLO0;
      2'b10:   wake_dest = MODE_SOLO1;
      default: wake_dest = MODE_DSLEEP;
    endcase
  end
endmodule

// File: rtl/dual_core_pmc.sv
module dual_core_pmc
  import pmc_pkg::*;
#(
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             por_rst,
  input  logic             man_rst,
  input  logic             cpu0_sleep,
  input  logic             cpu1_sleep,
  input  logic             stby_sel,
  input  logic             slperr_en,
  input  logic             irq_req,
  input  logic             irq_nmi,
  input  logic [LVL_W-1:0] irq_lvl,
  input  logic [LVL_W-1:0] cpu0_mask,
  input  logic [LVL_W-1:0] cpu1_mask,
  input  logic [1:0]       accept_en,
  output logic [1:0]       mode,
  output logic             cpu0_halt,
  output logic             cpu1_halt,
  output logic             sleep_err,
  output logic             irq_exc
);
  localparam int NCPU = 2;

  pmc_mode_e mode_q, mode_d;
  logic      any_rst;
  logic      sleep_move, sleep_fault, wake;
  pmc_mode_e sleep_dest, wake_dest;
  logic [NCPU-1:0][LVL_W-1:0] mask_vec;

  assign any_rst  = por_rst | man_rst;
  assign mask_vec = {cpu1_mask, cpu0_mask};

  pmc_sleep_gate u_sleep (
    .cur_mode    (mode_q),
    .cpu0_sleep  (cpu0_sleep),
    .cpu1_sleep  (cpu1_sleep),
    .stby_sel    (stby_sel),
    .slperr_en   (slperr_en),
    .sleep_move  (sleep_move),
    .sleep_dest  (sleep_dest),
    .sleep_fault (sleep_fault)
  );

  pmc_wake_arb #(.LVL_W(LVL_W), .NCPU(NCPU)) u_wake (
    .irq_req   (irq_req),
    .irq_nmi   (irq_nmi),
    .irq_lvl   (irq_lvl),
    .cpu_mask  (mask_vec),
    .accept_en (accept_en),
    .wake      (wake),
    .wake_dest (wake_dest)
  );

  logic do_wake;
  assign do_wake = (mode_q == MODE_DSLEEP) && wake;

  always_comb begin
    mode_d = mode_q;
    if (do_wake)         mode_d = wake_dest;
    else if (sleep_move) mode_d = sleep_dest;
  end

  always_ff @(posedge clk) begin
    if (any_rst) begin
      mode_q    <= MODE_DUAL;
      sleep_err <= 1'b0;
      irq_exc   <= 1'b0;
    end else begin
      mode_q    <= mode_d;
      sleep_err <= sleep_fault;
      irq_exc   <= do_wake;
    end
  end

  assign mode      = mode_q;
  assign cpu0_halt = (mode_q == MODE_SOLO1) || (mode_q == MODE_DSLEEP);
  assign cpu1_halt = (mode_q == MODE_SOLO0) || (mode_q == MODE_DSLEEP);

  // Assertions
  p_reset_dual_r1: assert property (@(posedge clk)
    any_rst |=> (mode == 2'b00 && !sleep_err && !irq_exc));

  p_err_holds_r4: assert property (@(posedge clk) disable iff (any_rst)
    (mode == 2'b01 && cpu0_sleep && slperr_en) |=> (sleep_err && mode == 2'b01));

  p_solo1_sleep_r6: assert property (@(posedge clk) disable iff (any_rst)
    (mode == 2'b10 && cpu1_sleep) |=> (mode == 2'b11));

  p_dual_split_r7: assert property (@(posedge clk) disable iff (any_rst)
    (mode == 2'b00 && cpu1_sleep) |=> (mode == 2'b01 && cpu0_halt == 1'b0));

  p_stay_asleep_r10: assert property (@(posedge clk) disable iff (any_rst)
    (mode == 2'b11 && !irq_req) |=> (mode == 2'b11 && !irq_exc));

  p_nmi_wake_r12: assert property (@(posedge clk) disable iff (any_rst)
    (mode == 2'b11 && irq_req && irq_nmi && accept_en != 2'b00) |=> (irq_exc && mode != 2'b11));
endmodule

// File: tb/tb_dual_core_pmc.sv
`timescale 1ns/1ps
module tb_dual_core_pmc;
  localparam int LVL_W = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic por, man, s0, s1, sb, se, rq, nmi;
  logic [LVL_W-1:0] lvl, m0, m1;
  logic [1:0] en;
  logic [1:0] mode;
  logic h0, h1, err, exc;

  dual_core_pmc #(.LVL_W(LVL_W)) dut (
    .clk(clk), .por_rst(por), .man_rst(man),
    .cpu0_sleep(s0), .cpu1_sleep(s1), .stby_sel(sb), .slperr_en(se),
    .irq_req(rq), .irq_nmi(nmi), .irq_lvl(lvl),
    .cpu0_mask(m0), .cpu1_mask(m1), .accept_en(en),
    .mode(mode), .cpu0_halt(h0), .cpu1_halt(h1),
    .sleep_err(err), .irq_exc(exc)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [1:0] exp_mode = 2'b00;

  task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  // Returns {next_mode, sleep_err, irq_exc} from the requirements.
  function automatic logic [3:0] model(input logic [1:0] m);
    logic [1:0] n;
    logic e, x, t0, t1;
    n = m; e = 1'b0; x = 1'b0;
    if (por || man) n = 2'b00;
    else begin
      case (m)
        2'b00: if (s1) n = 2'b01; else if (s0) n = 2'b10;
        2'b01: if (s0) begin
                 if (se) e = 1'b1;
                 else if (!sb) n = 2'b11;
               end
        2'b10: if (s1) n = 2'b11;
        default: begin
          t0 = rq && en[0] && (nmi || lvl > m0);
          t1 = rq && en[1] && (nmi || lvl > m1);
          if (t0 && t1) n = 2'b00;
          else if (t0)  n = 2'b01;
          else if (t1)  n = 2'b10;
          x = t0 | t1;
        end
      endcase
    end
    return {n, e, x};
  endfunction

  function automatic string classify(input logic [1:0] m);
    if (por || man) return "R1";
    case (m)
      2'b00: return "R7";
      2'b01: return s0 ? (se ? "R4" : (sb ? "R5" : "R3")) : "R8";
      2'b10: return s1 ? "R6" : "R8";
      default: return rq ? "R11" : "R8";
    endcase
  endfunction

  task automatic idle();
    por = 0; man = 0; s0 = 0; s1 = 0; sb = 0; se = 0;
    rq = 0; nmi = 0; lvl = '0; m0 = '0; m1 = '0; en = 2'b00;
  endtask

  // Called just after a falling edge with inputs set; checks after the rising edge.
  task automatic cyc(input string tag);
    logic [3:0] r;
    r = model(exp_mode);
    @(posedge clk); #1;
    exp_mode = r[3:2];
    chk(tag, mode, exp_mode);
    chk("R9 halt0", {1'b0, h0}, {1'b0, exp_mode == 2'b10 || exp_mode == 2'b11});
    chk("R9 halt1", {1'b0, h1}, {1'b0, exp_mode == 2'b01 || exp_mode == 2'b11});
    chk("R4 sleep_err", {1'b0, err}, {1'b0, r[1]});
    chk("R12 irq_exc", {1'b0, exc}, {1'b0, r[0]});
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5171));
    idle();
    por = 1;
    @(negedge clk);
    cyc("R1 R2 reset state");
    // R7: processor 0 sleeps in dual mode
    s0 = 1; cyc("R7 dual to solo1");
    // R8: halted processor 0 strobe ignored
    s0 = 1; se = 1; cyc("R8 halted strobe");
    // R6: processor 1 ignores both bits
    s1 = 1; sb = 1; se = 1; cyc("R6 solo1 sleep");
    // R8: strobes in dual-sleep ignored
    s0 = 1; s1 = 1; cyc("R8 strobes asleep");
    // R10: level equal to both masks stays asleep
    rq = 1; lvl = 4'd5; m0 = 4'd5; m1 = 4'd5; en = 2'b11; cyc("R10 equal level");
    // R10/R11: only processor 0 passes its mask
    rq = 1; lvl = 4'd6; m0 = 4'd5; m1 = 4'd9; en = 2'b11; cyc("R11 wake solo0");
    // R5: standby bit blocks dual-sleep
    s0 = 1; sb = 1; cyc("R5 standby");
    // R4: sleep error wins over standby
    s0 = 1; sb = 1; se = 1; cyc("R4 sleep error");
    // R12: interrupt while awake leaves strobe low
    rq = 1; nmi = 1; en = 2'b11; cyc("R12 awake irq");
    // R3: dual-sleep entry
    s0 = 1; cyc("R3 solo0 sleep");
    // R11: accepted NMI but no processor enabled
    rq = 1; nmi = 1; en = 2'b00; cyc("R11 none enabled");
    // R11: only processor 1 enabled
    rq = 1; lvl = 4'd15; m1 = 4'd3; en = 2'b10; cyc("R11 wake solo1");
    s1 = 1; cyc("R6 again");
    // R1: reset beats simultaneous NMI wake
    man = 1; rq = 1; nmi = 1; en = 2'b11; cyc("R1 reset vs wake");
    // R7: both strobes in dual mode
    s0 = 1; s1 = 1; cyc("R7 both strobes");

    for (int i = 0; i < 4000; i++) begin
      int p;
      p = $urandom_range(99);
      por = (p < 2);
      man = (p >= 2 && p < 4);
      s0  = ($urandom_range(99) < 30);
      s1  = ($urandom_range(99) < 30);
      sb  = $urandom_range(1);
      se  = ($urandom_range(99) < 35);
      rq  = ($urandom_range(99) < 40);
      nmi = ($urandom_range(99) < 20);
      lvl = LVL_W'($urandom_range(15));
      m0  = LVL_W'($urandom_range(15));
      m1  = LVL_W'($urandom_range(15));
      en  = 2'($urandom_range(3));
      cyc(classify(exp_mode));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule